// File: doc/BRIEF.md
# Local Bus Master Cycle Sequencer

This block runs the master side of a 32-bit local bus whose address and data travel on separate wires. An internal client hands it one transfer at a time through a valid/ready request port. Each request carries:

- a word address, a direction and active-high byte enables;
- a beat count for bursts and the bus width (8, 16 or 32 bits);
- lock flags for atomic sequences;
- the timing settings of the addressed region.

The sequencer opens every access with one address cycle that pulses the address strobe and the latch enable. For reads only, it may then insert programmable read-address wait states, with an optional read strobe delay inside them. It then runs the data beats, incrementing the word address after each completed beat. Between read beats it can insert read-data wait states. Each access closes with one end cycle.

A beat completes on the ready input. When the region allows it, a burst-terminate input can complete the beat instead. Read data returns one beat at a time with a valid pulse, and a done pulse marks the end cycle. For narrow buses, the write data is copied across all four byte lanes. The lock output spans a chain of locked transfers and releases one clock after the transfer that ends the chain.

Top module: `lbus_cycle_seq`

## Requirements
- R1: `lb_addr` changes only when a data beat completes. It then steps by one word, so beat k of a burst carries request address + k.
- R2: `lb_wdata` depends on `req_width`. With 0 (8-bit) it is the low byte of the request data in all four lanes. With 1 (16-bit) it is the low halfword in both halves. With 2 (32-bit) it is the data unchanged.
- R3: `lb_ads_n` is low and `lb_ale` is high for exactly one cycle, the cycle after a request is accepted, and at no other time.
- R4: When `req_bterm_en` is 1, a low `lb_bterm_n` in a data cycle completes the beat even with `lb_rdy_n` high. When it is 0, `lb_bterm_n` has no effect: address and responses stay unchanged until `lb_rdy_n` goes low.
- R5: `lb_be_n` equals the inverted request byte enables from the address cycle through the last data cycle. It is all ones in the end cycle and when idle.
- R6: `lb_lock_n` goes low in the address cycle of a request with `req_lock`=1. It stays low across following transfers, and goes high one clock after the end cycle of a transfer with `req_lock_end`=1.
- R7: `lb_wr` is 1 for a write and 0 for a read from the address cycle to the end of the transfer.
- R8: For reads, `lb_rd_n` is low in every data cycle and read-data wait cycle. In read-address wait cycle i (counting from 0) it is low when i >= `req_rd_dly`. It is high in the address cycle, the end cycle and throughout writes.
- R9: A read spends `req_nrad` cycles between the address cycle and the first data cycle, and `req_nrdd` cycles between one completed beat and the next data cycle. Writes skip both wait counts.
- R10: `req_ready` is high only when idle. `rsp_valid` pulses with the sampled `lb_rdata` in the cycle after each completed read beat. `rsp_done` is high in the single end cycle that follows the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_addr | input | 26 | Starting word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables, active high |
| req_beats | input | 4 | Number of beats minus one |
| req_width | input | 2 | Bus width: 0 = 8, 1 = 16, 2 = 32 bits |
| req_wdata | input | 32 | Write data, held for every beat |
| req_lock | input | 1 | Transfer belongs to an atomic chain |
| req_lock_end | input | 1 | Transfer closes the atomic chain |
| req_bterm_en | input | 1 | Region lets burst-terminate complete beats |
| req_rd_dly | input | 2 | Read strobe delay in clocks |
| req_nrad | input | 5 | Read-address wait states |
| req_nrdd | input | 5 | Read-data wait states |
| lb_ads_n | output | 1 | Address strobe, active low |
| lb_ale | output | 1 | Address latch enable |
| lb_addr | output | 26 | Word address |
| lb_be_n | output | 4 | Byte enables, active low |
| lb_wr | output | 1 | Direction, high for write |
| lb_rd_n | output | 1 | Read strobe, active low |
| lb_lock_n | output | 1 | Lock, active low |
| lb_wdata | output | 32 | Write data, lane-replicated |
| lb_rdata | input | 32 | Read data from the bus |
| lb_rdy_n | input | 1 | Ready, active low |
| lb_bterm_n | input | 1 | Burst terminate, active low |
| rsp_valid | output | 1 | Read beat data valid |
| rsp_rdata | output | 32 | Read beat data |
| rsp_done | output | 1 | Transfer finished |

## Verification
The hardest situation to reach is a read-address wait window whose strobe delay exceeds the wait count. In that case the read strobe must first fall in the data cycle, never inside the window. The bench issues a read with two address wait states and a delay of three, and checks the strobe cycle by cycle. A second hard case is a burst-terminate pulse arriving while the region forbids it. The bench holds terminate low for two data cycles with ready high, expects no response and no address step, and only then completes the beat with ready. The lock chain is covered by two locked transfers followed by an unlocked one.

// File: rtl/lbus_seq_pkg.sv
package lbus_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ADDR      = 3'd1,
        ST_WAIT_ADDR = 3'd2,
        ST_DATA      = 3'd3,
        ST_WAIT_DATA = 3'd4,
        ST_END       = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        BW_8  = 2'd0,
        BW_16 = 2'd1,
        BW_32 = 2'd2
    } bus_width_e;

endpackage

// File: rtl/lbus_lane_rep.sv
module lbus_lane_rep
    import lbus_seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    width,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int LANES = DW / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if (width == BW_8)
                dout[8*i +: 8] = din[7:0];
            else if (width == BW_16)
                dout[8*i +: 8] = din[8*(i % 2) +: 8];
            else
                dout[8*i +: 8] = din[8*i +: 8];
        end
    end
endmodule

// File: rtl/lbus_ready_sel.sv
module lbus_ready_sel (
    input  logic in_data,
    input  logic bterm_en,
    input  logic rdy_n,
    input  logic bterm_n,
    output logic beat
);
    logic term_hit;

    always_comb begin
        term_hit = bterm_en && !bterm_n;
        beat     = in_data && (term_hit || !rdy_n);
    end
endmodule

// File: rtl/lbus_cycle_seq.sv
module lbus_cycle_seq
    import lbus_seq_pkg::*;
#(
    parameter int AW     = 26,
    parameter int DW     = 32,
    parameter int LEN_W  = 4,
    parameter int WS_W   = 5,
    parameter int DLY_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_write,
    input  logic [DW/8-1:0]  req_be,
    input  logic [LEN_W-1:0] req_beats,
    input  logic [1:0]       req_width,
    input  logic [DW-1:0]    req_wdata,
    input  logic             req_lock,
    input  logic             req_lock_end,
    input  logic             req_bterm_en,
    input  logic [DLY_W-1:0] req_rd_dly,
    input  logic [WS_W-1:0]  req_nrad,
    input  logic [WS_W-1:0]  req_nrdd,
    output logic             lb_ads_n,
    output logic             lb_ale,
    output logic [AW-1:0]    lb_addr,
    output logic [DW/8-1:0]  lb_be_n,
    output logic             lb_wr,
    output logic             lb_rd_n,
    output logic             lb_lock_n,
    output logic [DW-1:0]    lb_wdata,
    input  logic [DW-1:0]    lb_rdata,
    input  logic             lb_rdy_n,
    input  logic             lb_bterm_n,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic             rsp_done
);
    localparam int BEW = DW / 8;

    typedef struct packed {
        seq_state_e       st;
        logic [AW-1:0]    addr;
        logic [BEW-1:0]   be;
        logic             wr;
        logic [1:0]       width;
        logic [DW-1:0]    wdata;
        logic [LEN_W-1:0] left;
        logic [WS_W-1:0]  nrad;
        logic [WS_W-1:0]  nrdd;
        logic [WS_W-1:0]  wcnt;
        logic [DLY_W-1:0] dly;
        logic             bten;
        logic             lock;
        logic             lend;
        logic             rvalid;
        logic [DW-1:0]    rdata;
    } seq_t;

    seq_t q, d;
    logic beat;
    logic busy;

    lbus_ready_sel u_rsel (
        .in_data  (q.st == ST_DATA),
        .bterm_en (q.bten),
        .rdy_n    (lb_rdy_n),
        .bterm_n  (lb_bterm_n),
        .beat     (beat)
    );

    lbus_lane_rep #(.DW(DW)) u_lane (
        .width (q.width),
        .din   (q.wdata),
        .dout  (lb_wdata)
    );

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_ADDR;
                    d.addr  = req_addr;
                    d.be    = req_be;
                    d.wr    = req_write;
                    d.width = req_width;
                    d.wdata = req_wdata;
                    d.left  = req_beats;
                    d.nrad  = req_nrad;
                    d.nrdd  = req_nrdd;
                    d.dly   = req_rd_dly;
                    d.bten  = req_bterm_en;
                    d.lend  = req_lock_end;
                    d.lock  = q.lock | req_lock;
                    d.wcnt  = '0;
                end
            end
            ST_ADDR: begin
                d.wcnt = '0;
                d.st   = (!q.wr && q.nrad != '0) ? ST_WAIT_ADDR : ST_DATA;
            end
            ST_WAIT_ADDR: begin
                if (q.wcnt == q.nrad - 1'b1) begin
                    d.st   = ST_DATA;
                    d.wcnt = '0;
                end else begin
                    d.wcnt = q.wcnt + 1'b1;
                end
            end
            ST_DATA: begin
                if (beat) begin
                    d.wcnt = '0;
                    if (!q.wr) begin
                        d.rvalid = 1'b1;
                        d.rdata  = lb_rdata;
                    end
                    if (q.left == '0) begin
                        d.st = ST_END;
                    end else begin
                        d.left = q.left - 1'b1;
                        d.addr = q.addr + 1'b1;
                        d.st   = (!q.wr && q.nrdd != '0) ? ST_WAIT_DATA : ST_DATA;
                    end
                end
            end
            ST_WAIT_DATA: begin
                if (q.wcnt == q.nrdd - 1'b1) begin
                    d.st   = ST_DATA;
                    d.wcnt = '0;
                end else begin
                    d.wcnt = q.wcnt + 1'b1;
                end
            end
            ST_END: begin
                d.st = ST_IDLE;
                if (q.lend)
                    d.lock = 1'b0;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    always_comb begin
        busy      = (q.st == ST_ADDR) || (q.st == ST_WAIT_ADDR) ||
                    (q.st == ST_DATA) || (q.st == ST_WAIT_DATA);
        req_ready = (q.st == ST_IDLE);
        lb_ads_n  = !(q.st == ST_ADDR);
        lb_ale    = (q.st == ST_ADDR);
        lb_addr   = q.addr;
        lb_be_n   = busy ? ~q.be : '1;
        lb_wr     = q.wr;
        lb_rd_n   = !(!q.wr && (((q.st == ST_WAIT_ADDR) && (q.wcnt >= WS_W'(q.dly))) ||
                                (q.st == ST_DATA) || (q.st == ST_WAIT_DATA)));
        lb_lock_n = !q.lock;
        rsp_valid = q.rvalid;
        rsp_rdata = q.rdata;
        rsp_done  = (q.st == ST_END);
    end
endmodule

// File: rtl/lbus_cycle_seq_chk.sv
module lbus_cycle_seq_chk #(
    parameter int AW = 26,
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            lb_ads_n,
    input logic            lb_ale,
    input logic [AW-1:0]   lb_addr,
    input logic [DW/8-1:0] lb_be_n,
    input logic            lb_wr,
    input logic            lb_rd_n,
    input logic            lb_lock_n,
    input logic            lb_rdy_n,
    input logic            lb_bterm_n,
    input logic            rsp_valid,
    input logic            rsp_done
);
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_be_n != '1 && lb_rdy_n && lb_bterm_n) |=> $stable(lb_addr)); // R1

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_done) |-> lb_addr == $past(lb_addr) + 1'b1); // R1

    AST_ADS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lb_ads_n |=> lb_ads_n); // R3

    AST_ACCEPT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!lb_ads_n && lb_ale)); // R3

    AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (lb_be_n == '1 && lb_ads_n)); // R5

    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lb_lock_n) |-> $past(rsp_done)); // R6

    AST_WRITE_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        lb_wr |-> lb_rd_n); // R8
endmodule

bind lbus_cycle_seq lbus_cycle_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .lb_ads_n   (lb_ads_n),
    .lb_ale     (lb_ale),
    .lb_addr    (lb_addr),
    .lb_be_n    (lb_be_n),
    .lb_wr      (lb_wr),
    .lb_rd_n    (lb_rd_n),
    .lb_lock_n  (lb_lock_n),
    .lb_rdy_n   (lb_rdy_n),
    .lb_bterm_n (lb_bterm_n),
    .rsp_valid  (rsp_valid),
    .rsp_done   (rsp_done)
);

// File: tb/lbus_cycle_seq_bench.sv
module lbus_cycle_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [25:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [3:0]  req_be = '0;
    logic [3:0]  req_beats = '0;
    logic [1:0]  req_width = 2'd2;
    logic [31:0] req_wdata = '0;
    logic        req_lock = 1'b0;
    logic        req_lock_end = 1'b0;
    logic        req_bterm_en = 1'b0;
    logic [1:0]  req_rd_dly = '0;
    logic [4:0]  req_nrad = '0;
    logic [4:0]  req_nrdd = '0;
    logic        lb_ads_n, lb_ale, lb_wr, lb_rd_n, lb_lock_n;
    logic [25:0] lb_addr;
    logic [3:0]  lb_be_n;
    logic [31:0] lb_wdata, lb_rdata;
    logic        lb_rdy_n = 1'b1;
    logic        lb_bterm_n = 1'b1;
    logic        rsp_valid, rsp_done;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 0;
    bit lock_exp = 0;
    logic [31:0] exp_q[$];

    always #2 clk = ~clk;

    assign lb_rdata = {~lb_addr[5:0], lb_addr};

    lbus_cycle_seq u_lbus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
        .req_beats(req_beats), .req_width(req_width), .req_wdata(req_wdata),
        .req_lock(req_lock), .req_lock_end(req_lock_end),
        .req_bterm_en(req_bterm_en), .req_rd_dly(req_rd_dly),
        .req_nrad(req_nrad), .req_nrdd(req_nrdd),
        .lb_ads_n(lb_ads_n), .lb_ale(lb_ale), .lb_addr(lb_addr),
        .lb_be_n(lb_be_n), .lb_wr(lb_wr), .lb_rd_n(lb_rd_n),
        .lb_lock_n(lb_lock_n), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata),
        .lb_rdy_n(lb_rdy_n), .lb_bterm_n(lb_bterm_n),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done)
    );

    task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] rep(input logic [1:0] w, input logic [31:0] v);
        if (w == 2'd0) return {4{v[7:0]}};
        if (w == 2'd1) return {2{v[15:0]}};
        return v;
    endfunction

    // Monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                ck("R10 unexpected rsp_valid", 32'd1, 32'd0);
            end else begin
                ck("R10 read data", rsp_rdata, exp_q.pop_front());
            end
        end
    end

    // src: 0 = ready, 1 = burst-terminate enabled, 2 = terminate while disabled then ready
    task automatic xfer(input logic wr, input logic [25:0] a, input logic [3:0] nb,
                        input logic [1:0] w, input logic [3:0] be,
                        input logic [4:0] nrad, input logic [4:0] nrdd,
                        input logic [1:0] dly, input logic lk, input logic lend,
                        input int src);
        req_valid = 1; req_write = wr; req_addr = a; req_beats = nb; req_width = w;
        req_be = be; req_wdata = 32'hA1B2C3D4; req_lock = lk; req_lock_end = lend;
        req_bterm_en = (src == 1); req_rd_dly = dly; req_nrad = nrad; req_nrdd = nrdd;
        ck("R10 ready when idle", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 0;
        lock_exp = lock_exp | lk;
        // address cycle
        ck("R3 ads_n in address cycle", {31'd0, lb_ads_n}, 32'd0);
        ck("R3 ale in address cycle", {31'd0, lb_ale}, 32'd1);
        ck("R1 start address", {6'd0, lb_addr}, {6'd0, a});
        ck("R5 byte enables", {28'd0, lb_be_n}, {28'd0, ~be});
        ck("R7 direction", {31'd0, lb_wr}, {31'd0, wr});
        ck("R6 lock in address cycle", {31'd0, lb_lock_n}, {31'd0, !lock_exp});
        ck("R8 rd_n high in address cycle", {31'd0, lb_rd_n}, 32'd1);
        ck("R10 not ready when busy", {31'd0, req_ready}, 32'd0);
        if (!wr) begin
            for (int i = 0; i < int'(nrad); i++) begin
                @(negedge clk);
                ck("R9 still waiting (no ads)", {31'd0, lb_ads_n}, 32'd1);
                ck("R8 rd_n in address wait", {31'd0, lb_rd_n}, {31'd0, (i < int'(dly))});
                ck("R1 address held in wait", {6'd0, lb_addr}, {6'd0, a});
            end
        end
        for (int b = 0; b <= int'(nb); b++) begin
            @(negedge clk);
            ck("R1 beat address", {6'd0, lb_addr}, {6'd0, a + 26'(b)});
            ck("R8 rd_n in data cycle", {31'd0, lb_rd_n}, {31'd0, wr});
            ck("R5 byte enables in data", {28'd0, lb_be_n}, {28'd0, ~be});
            if (wr) ck("R2 lane replication", lb_wdata, rep(w, 32'hA1B2C3D4));
            if (src == 2) begin
                lb_bterm_n = 0;
                for (int s = 0; s < 2; s++) begin
                    @(negedge clk);
                    ck("R4 terminate ignored (addr)", {6'd0, lb_addr}, {6'd0, a + 26'(b)});
                    ck("R4 terminate ignored (no rsp)", {31'd0, rsp_valid}, 32'd0);
                end
                lb_bterm_n = 1;
                lb_rdy_n = 0;
            end else if (src == 1) begin
                lb_bterm_n = 0;
            end else begin
                lb_rdy_n = 0;
            end
            if (!wr) exp_q.push_back({~(a[5:0] + 6'(b)), a + 26'(b)});
            @(posedge clk);
            #1;
            lb_rdy_n = 1; lb_bterm_n = 1;
            if (!wr && b < int'(nb)) begin
                for (int i = 0; i < int'(nrdd); i++) begin
                    @(negedge clk);
                    ck("R9 read-data wait strobe", {31'd0, lb_rd_n}, 32'd0);
                    ck("R9 wait keeps next address", {6'd0, lb_addr}, {6'd0, a + 26'(b + 1)});
                end
            end
        end
        @(negedge clk);
        ck("R10 done in end cycle", {31'd0, rsp_done}, 32'd1);
        ck("R5 byte enables released", {28'd0, lb_be_n}, 32'hF);
        ck("R8 rd_n high at end", {31'd0, lb_rd_n}, 32'd1);
        ck("R6 lock held through end", {31'd0, lb_lock_n}, {31'd0, !lock_exp});
        if (lend) lock_exp = 0;
        @(negedge clk);
        ck("R6 lock after end", {31'd0, lb_lock_n}, {31'd0, !lock_exp});
        ck("R10 done is one cycle", {31'd0, rsp_done}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        ck("R3 reset ads_n", {31'd0, lb_ads_n}, 32'd1);
        ck("R3 reset ale", {31'd0, lb_ale}, 32'd0);
        ck("R5 reset byte enables", {28'd0, lb_be_n}, 32'hF);
        ck("R8 reset rd_n", {31'd0, lb_rd_n}, 32'd1);
        ck("R6 reset lock", {31'd0, lb_lock_n}, 32'd1);
        ck("R10 reset rsp", {30'd0, rsp_valid, rsp_done}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        ck("R10 ready after reset", {31'd0, req_ready}, 32'd1);
        // single read, no waits
        xfer(0, 26'h0000100, 4'd0, 2'd2, 4'hF, 5'd0, 5'd0, 2'd0, 0, 0, 0);
        // burst read with address and data waits (R9)
        xfer(0, 26'h1234560, 4'd3, 2'd2, 4'hF, 5'd3, 5'd2, 2'd0, 0, 0, 0);
        // strobe delay inside the wait window (R8)
        xfer(0, 26'h0ABCDEF, 4'd1, 2'd2, 4'h3, 5'd4, 5'd0, 2'd2, 0, 0, 0);
        // strobe delay longer than the wait window (R8)
        xfer(0, 26'h00000FE, 4'd0, 2'd2, 4'hF, 5'd2, 5'd0, 2'd3, 0, 0, 0);
        // writes at three widths, wait counts ignored (R2, R9)
        xfer(1, 26'h0000200, 4'd2, 2'd0, 4'h1, 5'd7, 5'd3, 2'd0, 0, 0, 0);
        xfer(1, 26'h0000300, 4'd1, 2'd1, 4'h3, 5'd5, 5'd5, 2'd1, 0, 0, 0);
        xfer(1, 26'h3FFFFFE, 4'd1, 2'd2, 4'hF, 5'd0, 5'd0, 2'd0, 0, 0, 0);
        // burst-terminate enabled completes beats (R4)
        xfer(0, 26'h0000400, 4'd2, 2'd2, 4'hF, 5'd1, 5'd1, 2'd0, 0, 0, 1);
        // burst-terminate while disabled is ignored (R4)
        xfer(0, 26'h0000500, 4'd1, 2'd2, 4'hF, 5'd0, 5'd0, 2'd0, 0, 0, 2);
        // atomic chain: locked read, locked write closing the chain, then plain read (R6)
        xfer(0, 26'h0000600, 4'd1, 2'd2, 4'hF, 5'd1, 5'd0, 2'd0, 1, 0, 0);
        ck("R6 lock held between locked transfers", {31'd0, lb_lock_n}, 32'd0);
        xfer(1, 26'h0000700, 4'd0, 2'd2, 4'hF, 5'd0, 5'd0, 2'd0, 1, 1, 0);
        xfer(0, 26'h0000800, 4'd0, 2'd2, 4'hF, 5'd0, 5'd0, 2'd0, 0, 0, 0);
        repeat (2) @(negedge clk);
        ck("R10 all read beats returned", exp_q.size(), 32'd0);
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule